// File: doc/BRIEF.md
# Data Watchpoint Exception Unit

This unit watches the physical addresses of loads and stores in a processor's memory pipeline and requests a debug exception when one of them hits a programmed doubleword. Two software-written registers hold the watch: a low word with the lower address bits and separate arm bits for loads and stores, and a high word with the upper address bits. Cache-maintenance operations are never compared.

When a hit occurs while the exception-level or error-level status bit is set, the access is allowed to complete and the unit instead remembers a deferred watch. A two-state machine holds this. `WS_IDLE` is the state with nothing remembered. `WS_PENDING` is the state where a masked hit is waiting. The transitions are: `ARM` (from `WS_IDLE` to `WS_PENDING`, on a masked hit with no low-word write), `DELIVER` (from `WS_PENDING` to `WS_IDLE`, when both status bits are clear) and `CANCEL` (from `WS_PENDING` to `WS_IDLE`, on any low-word write). An unmasked hit in `WS_IDLE` is the self-loop `FIRE`, which raises the request at once. A delivered deferred watch tells the exception logic that the return address is the next unexecuted instruction and not the faulting one.

The request, the cause code and the return-address selection are registered. They appear one cycle after the access or status condition that produces them. Vectoring and any cache side effects belong to the surrounding core.

Top module: `dwatch_unit`

## Requirements
- R1: After reset both watch registers read as zero, `exc_req` and `epc_next` are 0, `exc_code` is 0, and nothing is pending.
- R2: `reg_wr_sel`/`reg_rd_sel` = 0 selects the low word: bit 0 arms stores, bit 1 arms loads, bit 2 always reads 0, and bits [31:3] hold address bits [31:3]. Select = 1 selects the high word: bits [7:0] hold address bits [39:32], and bits [31:8] read 0. A write takes effect at the next clock edge. The read port is combinational.
- R3: A hit requires `acc_paddr[39:3]` to equal the programmed address. `acc_paddr[2:0]` does not affect the result.
- R4: A load hits only when the load arm bit is 1. A store hits only when the store arm bit is 1.
- R5: An access with `acc_is_cache` = 1 never hits, whatever its address and type.
- R6: In `WS_IDLE`, a hit with `stat_exl` = `stat_erl` = 0 gives `exc_req` = 1 with `epc_next` = 0 in the next cycle. This holds even if the low word is written in the same cycle, because the hit is compared against the old contents.
- R7: In `WS_IDLE`, a hit with either status bit set gives no request and enters `WS_PENDING`, unless the low word is written in the same cycle.
- R8: In `WS_PENDING`, when both status bits are 0 and there is no low-word write, the next cycle has `exc_req` = 1 with `epc_next` = 1, and the state returns to `WS_IDLE`. An access in that same cycle raises no second request.
- R9: Any low-word write in `WS_PENDING` returns the state to `WS_IDLE` with no request. A high-word write leaves a pending watch in place.
- R10: `exc_code` is 23 in every cycle where `exc_req` is 1, and 0 otherwise. Each taken exception holds `exc_req` for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 low word, 1 high word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 1 | Read target: 0 low word, 1 high word |
| reg_rd_data | output | 32 | Combinational read data |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_is_load | input | 1 | The access is a load |
| acc_is_store | input | 1 | The access is a store |
| acc_is_cache | input | 1 | The access is a cache-maintenance operation |
| acc_paddr | input | 40 | Physical address of the access |
| stat_exl | input | 1 | Exception-level status bit |
| stat_erl | input | 1 | Error-level status bit |
| exc_req | output | 1 | Watch exception request, one cycle per exception |
| exc_code | output | 5 | Cause code (23 during a request) |
| epc_next | output | 1 | 1: return to the next unexecuted instruction (deferred delivery) |

## Verification
The properties assume that `acc_is_load` and `acc_is_store` are never both 1 for a single access. They also assume that status and access inputs are stable across each rising edge. The stimulus keeps to both assumptions: it picks one access kind per cycle and changes every input only at the falling edge. Random addresses are drawn half the time from the programmed doubleword with random low bits, so hits, masked hits and deferred deliveries all occur often. The status bits are biased so that pending watches both build up and drain.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
    localparam int DW_PA_W     = 40;  // physical address width
    localparam int DW_REG_W    = 32;  // register word width
    localparam int DW_GRAN     = 3;   // log2 of compare granule in bytes
    localparam int DW_CODE_W   = 5;   // cause code width
    localparam int DW_WATCH_CODE = 23;

    typedef enum logic [0:0] {
        WS_IDLE    = 1'b0,
        WS_PENDING = 1'b1
    } wstate_e;
endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs #(
    parameter int PA_W  = 40,
    parameter int REG_W = 32,
    parameter int GRAN  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 rd_sel,
    output logic [REG_W-1:0]     rd_data,
    output logic [PA_W-1:GRAN]   watch_addr,
    output logic                 ld_arm,
    output logic                 st_arm,
    output logic                 wr_lo
);
    localparam int HI_W  = PA_W - REG_W;
    localparam int RSV_W = GRAN - 2;

    logic [REG_W-1:GRAN] lo_addr_q;
    logic [HI_W-1:0]     hi_addr_q;
    logic                ld_arm_q;
    logic                st_arm_q;

    assign wr_lo = wr_en && !wr_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_addr_q <= '0;
            hi_addr_q <= '0;
            ld_arm_q  <= 1'b0;
            st_arm_q  <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                lo_addr_q <= wr_data[REG_W-1:GRAN];
                ld_arm_q  <= wr_data[1];
                st_arm_q  <= wr_data[0];
            end else begin
                hi_addr_q <= wr_data[HI_W-1:0];
            end
        end
    end

    always_comb begin
        if (!rd_sel) begin
            rd_data = {lo_addr_q, {RSV_W{1'b0}}, ld_arm_q, st_arm_q};
        end else begin
            rd_data = '0;
            rd_data[HI_W-1:0] = hi_addr_q;
        end
    end

    assign watch_addr = {hi_addr_q, lo_addr_q};
    assign ld_arm     = ld_arm_q;
    assign st_arm     = st_arm_q;
endmodule

// File: rtl/dwatch_match.sv
module dwatch_match #(
    parameter int PA_W = 40,
    parameter int GRAN = 3
) (
    input  logic               valid,
    input  logic               is_load,
    input  logic               is_store,
    input  logic               is_cache,
    input  logic [PA_W-1:GRAN] addr_dw,
    input  logic [PA_W-1:GRAN] watch_addr,
    input  logic               ld_arm,
    input  logic               st_arm,
    output logic               hit
);
    logic kind_ok;
    logic addr_eq;

    assign kind_ok = (is_load && ld_arm) || (is_store && st_arm);
    assign addr_eq = (addr_dw == watch_addr);
    assign hit     = valid && !is_cache && kind_ok && addr_eq;
endmodule

// File: rtl/dwatch_fsm.sv
module dwatch_fsm
    import dwatch_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int WATCH_CODE = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              masked,
    input  logic              wr_lo,
    output logic              exc_req,
    output logic [CODE_W-1:0] exc_code,
    output logic              epc_next,
    output logic              pending
);
    wstate_e state_q, state_d;
    logic    fire_now;
    logic    fire_def;

    always_comb begin
        state_d  = state_q;
        fire_now = 1'b0;
        fire_def = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (hit && !masked) begin
                    fire_now = 1'b1;          // FIRE
                end else if (hit && masked && !wr_lo) begin
                    state_d = WS_PENDING;     // ARM
                end
            end
            WS_PENDING: begin
                if (wr_lo) begin
                    state_d = WS_IDLE;        // CANCEL
                end else if (!masked) begin
                    fire_def = 1'b1;          // DELIVER
                    state_d  = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req  <= 1'b0;
            exc_code <= '0;
            epc_next <= 1'b0;
        end else begin
            exc_req  <= fire_now || fire_def;
            exc_code <= (fire_now || fire_def) ? CODE_W'(WATCH_CODE) : '0;
            epc_next <= fire_def;
        end
    end

    assign pending = (state_q == WS_PENDING);
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
    import dwatch_pkg::*;
#(
    parameter int PA_W       = DW_PA_W,
    parameter int REG_W      = DW_REG_W,
    parameter int GRAN       = DW_GRAN,
    parameter int CODE_W     = DW_CODE_W,
    parameter int WATCH_CODE = DW_WATCH_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic              reg_rd_sel,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              acc_valid,
    input  logic              acc_is_load,
    input  logic              acc_is_store,
    input  logic              acc_is_cache,
    input  logic [PA_W-1:0]   acc_paddr,
    input  logic              stat_exl,
    input  logic              stat_erl,
    output logic              exc_req,
    output logic [CODE_W-1:0] exc_code,
    output logic              epc_next
);
    logic [PA_W-1:GRAN] watch_addr;
    logic               ld_arm;
    logic               st_arm;
    logic               wr_lo;
    logic               hit;
    logic               masked;
    logic               pending;

    assign masked = stat_exl || stat_erl;

    dwatch_regs #(.PA_W(PA_W), .REG_W(REG_W), .GRAN(GRAN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_sel),
        .rd_data    (reg_rd_data),
        .watch_addr (watch_addr),
        .ld_arm     (ld_arm),
        .st_arm     (st_arm),
        .wr_lo      (wr_lo)
    );

    dwatch_match #(.PA_W(PA_W), .GRAN(GRAN)) u_match (
        .valid      (acc_valid),
        .is_load    (acc_is_load),
        .is_store   (acc_is_store),
        .is_cache   (acc_is_cache),
        .addr_dw    (acc_paddr[PA_W-1:GRAN]),
        .watch_addr (watch_addr),
        .ld_arm     (ld_arm),
        .st_arm     (st_arm),
        .hit        (hit)
    );

    dwatch_fsm #(.CODE_W(CODE_W), .WATCH_CODE(WATCH_CODE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .masked   (masked),
        .wr_lo    (wr_lo),
        .exc_req  (exc_req),
        .exc_code (exc_code),
        .epc_next (epc_next),
        .pending  (pending)
    );
endmodule

// File: rtl/dwatch_checker.sv
module dwatch_checker #(
    parameter int CODE_W     = 5,
    parameter int WATCH_CODE = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hit,
    input logic              acc_valid,
    input logic              acc_is_cache,
    input logic              stat_exl,
    input logic              stat_erl,
    input logic              wr_lo,
    input logic              pending,
    input logic              exc_req,
    input logic [CODE_W-1:0] exc_code,
    input logic              epc_next
);
    assert_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_code == CODE_W'(WATCH_CODE));

    assert_quiet_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> exc_code == '0);

    assert_no_cache_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_is_cache) |-> !hit);

    assert_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !epc_next) |-> $past(hit && !stat_exl && !stat_erl));

    assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(hit && (stat_exl || stat_erl) && !wr_lo));

    assert_deliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && epc_next) |-> $past(pending && !stat_exl && !stat_erl && !wr_lo));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_lo) |=> (!pending && !exc_req));
endmodule

bind dwatch_unit dwatch_checker #(.CODE_W(CODE_W), .WATCH_CODE(WATCH_CODE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (hit),
    .acc_valid    (acc_valid),
    .acc_is_cache (acc_is_cache),
    .stat_exl     (stat_exl),
    .stat_erl     (stat_erl),
    .wr_lo        (wr_lo),
    .pending      (pending),
    .exc_req      (exc_req),
    .exc_code     (exc_code),
    .epc_next     (epc_next)
);

// File: tb/dwatch_unit_bench.sv
module dwatch_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en, reg_wr_sel, reg_rd_sel;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic        acc_valid, acc_is_load, acc_is_store, acc_is_cache;
    logic [39:0] acc_paddr;
    logic        stat_exl, stat_erl;
    logic        exc_req, epc_next;
    logic [4:0]  exc_code;

    int tests_run = 0;
    int tests_failed = 0;

    // bench model
    logic [31:3] m_lo_addr;
    logic [7:0]  m_hi;
    logic        m_ld, m_st, m_pend;
    logic        e_req, e_epc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwatch_unit u_dwatch_unit (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .acc_valid(acc_valid), .acc_is_load(acc_is_load), .acc_is_store(acc_is_store),
        .acc_is_cache(acc_is_cache), .acc_paddr(acc_paddr),
        .stat_exl(stat_exl), .stat_erl(stat_erl),
        .exc_req(exc_req), .exc_code(exc_code), .epc_next(epc_next)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic sel);
        return sel ? {24'h0, m_hi} : {m_lo_addr, 1'b0, m_ld, m_st};
    endfunction

    function automatic logic model_hit();
        return acc_valid && !acc_is_cache &&
               ((acc_is_load && m_ld) || (acc_is_store && m_st)) &&
               (acc_paddr[39:3] == {m_hi, m_lo_addr});
    endfunction

    // one clock: drive at negedge, predict, check readback, check outputs at next negedge
    task automatic cyc(input string tag, input logic wen, input logic wsel, input logic [31:0] wdat,
                       input logic rsel, input logic v, input logic ld, input logic st,
                       input logic cch, input logic [39:0] pa, input logic exl, input logic erl);
        logic h, msk, wlo;
        reg_wr_en = wen; reg_wr_sel = wsel; reg_wr_data = wdat; reg_rd_sel = rsel;
        acc_valid = v; acc_is_load = ld; acc_is_store = st; acc_is_cache = cch;
        acc_paddr = pa; stat_exl = exl; stat_erl = erl;
        #1;
        check({tag, " R2 read"}, reg_rd_data, exp_read(rsel));
        h = model_hit(); msk = exl || erl; wlo = wen && !wsel;
        e_req = 1'b0; e_epc = 1'b0;
        if (m_pend) begin
            if (wlo) m_pend = 1'b0;
            else if (!msk) begin e_req = 1'b1; e_epc = 1'b1; m_pend = 1'b0; end
        end else begin
            if (h && !msk) e_req = 1'b1;
            else if (h && msk && !wlo) m_pend = 1'b1;
        end
        if (wen) begin
            if (!wsel) begin m_lo_addr = wdat[31:3]; m_ld = wdat[1]; m_st = wdat[0]; end
            else m_hi = wdat[7:0];
        end
        @(negedge clk);
        check({tag, e_epc ? " R8 req" : " R6 req"}, 32'(exc_req), 32'(e_req));
        check({tag, " R10 code"}, 32'(exc_code), e_req ? 32'd23 : 32'd0);
        check({tag, " R8 epc"}, 32'(epc_next), 32'(e_epc));
    endtask

    task automatic wr(input string tag, input logic sel, input logic [31:0] d);
        cyc(tag, 1'b1, sel, d, sel, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0, 1'b0, 1'b0);
    endtask

    task automatic acc(input string tag, input logic ld, input logic st, input logic cch,
                       input logic [39:0] pa, input logic exl, input logic erl);
        cyc(tag, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, ld, st, cch, pa, exl, erl);
    endtask

    task automatic idle(input string tag, input logic exl, input logic erl);
        cyc(tag, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h0, exl, erl);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        tests_run++; tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        logic [39:0] wa;
        logic [39:0] pa;
        void'($urandom(32'd1234));
        m_lo_addr = '0; m_hi = '0; m_ld = 0; m_st = 0; m_pend = 0;
        rst_n = 1'b0;
        reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0; reg_rd_sel = 0;
        acc_valid = 0; acc_is_load = 0; acc_is_store = 0; acc_is_cache = 0;
        acc_paddr = 0; stat_exl = 0; stat_erl = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 req", 32'(exc_req), 32'd0);
        check("R1 code", 32'(exc_code), 32'd0);
        check("R1 epc", 32'(epc_next), 32'd0);
        check("R1 lo", reg_rd_data, 32'd0);
        rst_n = 1'b1;

        // R2 layout: all ones, bit 2 reads zero, high upper bits zero
        wr("R2 lo ones", 1'b0, 32'hFFFF_FFFF);
        wr("R2 hi ones", 1'b1, 32'hFFFF_FFFF);
        idle("R2 readback", 1'b0, 1'b0);

        wa = 40'hA5_1234_5678 & ~40'h7;
        wr("R2 hi", 1'b1, {24'h0, wa[39:32]});
        wr("R4 lo load only", 1'b0, {wa[31:3], 3'b010});
        // R3 low bits ignored, R6 immediate
        acc("R3 R6 load hit", 1'b1, 1'b0, 1'b0, wa | 40'h5, 1'b0, 1'b0);
        acc("R3 miss bit3", 1'b1, 1'b0, 1'b0, wa ^ 40'h8, 1'b0, 1'b0);
        acc("R3 miss bit39", 1'b1, 1'b0, 1'b0, wa ^ (40'h1 << 39), 1'b0, 1'b0);
        // R4 store not armed
        acc("R4 store unarmed", 1'b0, 1'b1, 1'b0, wa, 1'b0, 1'b0);
        wr("R4 lo store only", 1'b0, {wa[31:3], 3'b001});
        acc("R4 load unarmed", 1'b1, 1'b0, 1'b0, wa, 1'b0, 1'b0);
        acc("R4 store hit", 1'b0, 1'b1, 1'b0, wa | 40'h7, 1'b0, 1'b0);
        // R5 cache op
        acc("R5 cache", 1'b0, 1'b1, 1'b1, wa, 1'b0, 1'b0);
        // R7 masked, R8 delivery
        acc("R7 masked exl", 1'b0, 1'b1, 1'b0, wa, 1'b1, 1'b0);
        idle("R7 still masked", 1'b0, 1'b1);
        acc("R8 deliver with hit", 1'b0, 1'b1, 1'b0, wa, 1'b0, 1'b0);
        idle("R8 gone", 1'b0, 1'b0);
        // R9 low write cancels, high write does not
        acc("R9 arm", 1'b0, 1'b1, 1'b0, wa, 1'b0, 1'b1);
        cyc("R9 hi write keeps", 1'b1, 1'b1, {24'h0, wa[39:32]}, 1'b1,
            1'b0, 1'b0, 1'b0, 1'b0, 40'h0, 1'b1, 1'b0);
        cyc("R9 lo write cancels", 1'b1, 1'b0, {wa[31:3], 3'b011}, 1'b0,
            1'b0, 1'b0, 1'b0, 1'b0, 40'h0, 1'b0, 1'b0);
        idle("R9 nothing left", 1'b0, 1'b0);
        // R9 write in same cycle as masked hit blocks arming
        cyc("R9 write vs arm", 1'b1, 1'b0, {wa[31:3], 3'b011}, 1'b0,
            1'b1, 1'b1, 1'b0, 1'b0, wa, 1'b1, 1'b0);
        idle("R9 no delivery", 1'b0, 1'b0);
        // R6 write in same cycle as unmasked hit still fires
        cyc("R6 write vs fire", 1'b1, 1'b0, {wa[31:3], 3'b011}, 1'b0,
            1'b1, 1'b1, 1'b0, 1'b0, wa, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic wen, wsel, v, k, cch, exl, erl;
            logic [31:0] wd;
            wen  = ($urandom_range(0, 19) == 0);
            wsel = $urandom_range(0, 1);
            wd   = wsel ? {24'h0, wa[39:32] ^ 8'($urandom_range(0, 1))}
                        : {wa[31:3], 1'b0, 2'($urandom_range(0, 3))};
            v    = ($urandom_range(0, 3) != 0);
            k    = $urandom_range(0, 1);
            cch  = ($urandom_range(0, 9) == 0);
            pa   = ($urandom_range(0, 1) == 1) ? ({m_hi, m_lo_addr, 3'b000} | 40'($urandom_range(0, 7)))
                                               : {8'($urandom), $urandom};
            exl  = ($urandom_range(0, 2) == 0);
            erl  = ($urandom_range(0, 4) == 0);
            cyc("rand R3 R4 R5 R6 R7 R8 R9", wen, wsel, wd, 1'($urandom_range(0, 1)),
                v, k, !k, cch, pa, exl, erl);
        end

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule